// File: doc/BRIEF.md
# Serial-Interface Watchdog with Alarm Request

This block guards the serial host link of a loop-powered current output. Each accepted register write, each write to the control register and each explicit no-operation command restarts a timeout counter. The counter advances on a one-millisecond enable from an external prescaler. If the host stays silent for the selected period, the block latches an interface-fault flag. That flag drives both the fault status bit and the fault output.

The block keeps its own copy of the watchdog fields of the 16-bit control word. It captures them on every control write. A 3-bit period code in bits 15:13 picks one of eight unevenly spaced periods. Bit 12 switches the watchdog off when set. Bit 10, when clear, makes an expiry also request that the loop current be forced to its alarm level. The fault stays latched until the host pulses the clear input.

Top module: `spi_wdog`

## Requirements
- R1: After reset, the fault output and the alarm request are low. The period code is 3'b011 (1000 ms), the watchdog is enabled and alarm forcing is on.
- R2: The period code is control bits 15:13, with bit 15 as the MSB. Codes 0 to 7 give 50, 100, 500, 1000, 2000, 3000, 4000 and 5000 ms.
- R3: With the watchdog enabled, the fault output rises after exactly P tick cycles (cycles with tick_ms high) following the most recent restart, where P is the selected period in ms. It is still low after P-1 ticks.
- R4: A cycle with reg_wr high restarts the count from zero.
- R5: A cycle with nop_cmd high restarts the count from zero.
- R6: A cycle with ctrl_wr high loads the new fields and restarts the count. The new period applies from that cycle onward.
- R7: While control bit 12 is 1, the count is held at zero and no new fault is raised. A fault that is already latched stays high.
- R8: Once raised, the fault output stays high until a cycle with fault_clr high.
- R9: alarm_force is high exactly while the fault is latched and control bit 10 is 0. With bit 10 at 1, an expiry still raises the fault but not alarm_force.
- R10: Cycles with tick_ms low do not advance the count.
- R11: Control bits 11 and 9:0 have no effect on the watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-millisecond count enable |
| reg_wr | input | 1 | Strobe: valid write to a register other than control |
| ctrl_wr | input | 1 | Strobe: valid write to the control register |
| ctrl_wdata | input | 16 | Control word carried with ctrl_wr |
| nop_cmd | input | 1 | Strobe: no-operation command received |
| fault_clr | input | 1 | Clears the latched interface fault |
| if_fault | output | 1 | Latched interface fault (status bit and fault output) |
| alarm_force | output | 1 | Request to drive loop current to alarm level |

## Verification
The bench uses the default TICKS_PER_MS of 1 and raises tick_ms on every counting cycle. Each millisecond of period therefore costs one clock, and even the 5000 ms code can be run to its exact expiry edge. This makes it practical to run all eight codes against both the P-1 and P tick boundaries. It also leaves room to hold the watchdog disabled for longer than the longest period, and to gate the tick off for long stretches.

// File: rtl/spi_wdog_pkg.sv
package spi_wdog_pkg;

    localparam int CODE_W     = 3;
    localparam int MAX_MS     = 5000;
    localparam int CTRL_W     = 16;
    localparam int CODE_MSB   = 15;
    localparam int CODE_LSB   = 13;
    localparam int DIS_BIT    = 12;
    localparam int ALOFF_BIT  = 10;
    localparam logic [CODE_W-1:0] CODE_RST = 3'b011;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              dis;
        logic              alarm_off;
    } wd_cfg_t;

    function automatic int period_ms(input logic [CODE_W-1:0] c);
        int p;
        case (c)
            3'd0:    p = 50;
            3'd1:    p = 100;
            3'd2:    p = 500;
            3'd3:    p = 1000;
            default: p = (int'(c) - 2) * 1000;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/spi_wdog_cfg.sv
module spi_wdog_cfg
    import spi_wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output wd_cfg_t           cfg
);
    wd_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (ctrl_wr) begin
            cfg_d.code      = ctrl_wdata[CODE_MSB:CODE_LSB];
            cfg_d.dis       = ctrl_wdata[DIS_BIT];
            cfg_d.alarm_off = ctrl_wdata[ALOFF_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.code      <= CODE_RST;
            cfg_q.dis       <= 1'b0;
            cfg_q.alarm_off <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/spi_wdog_timer.sv
module spi_wdog_timer
    import spi_wdog_pkg::*;
#(
    parameter int TICKS_PER_MS = 1,
    localparam int MAX_TICKS   = MAX_MS * TICKS_PER_MS,
    localparam int CNT_W       = $clog2(MAX_TICKS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              kick,
    input  logic              hold,
    input  logic [CODE_W-1:0] code,
    output logic              expire,
    output logic [CNT_W-1:0]  cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit  = CNT_W'(period_ms(code) * TICKS_PER_MS - 1);
        st_d   = st_q;
        expire = 1'b0;
        if (hold || kick) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt >= limit) begin
                expire   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/spi_wdog_fault.sv
module spi_wdog_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr,
    input  logic alarm_off,
    output logic fault,
    output logic alarm
);
    typedef struct packed {
        logic flag;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = expire | (st_q.flag & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fault = st_q.flag;
    assign alarm = st_q.flag & ~alarm_off;
endmodule

// File: rtl/spi_wdog.sv
module spi_wdog
    import spi_wdog_pkg::*;
#(
    parameter int TICKS_PER_MS = 1,
    localparam int CNT_W       = $clog2(MAX_MS * TICKS_PER_MS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ms,
    input  logic              reg_wr,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              nop_cmd,
    input  logic              fault_clr,
    output logic              if_fault,
    output logic              alarm_force
);
    wd_cfg_t          cfg;
    logic             kick;
    logic             expire;
    logic [CNT_W-1:0] tmr_cnt;
    logic             wd_dis;

    assign kick   = reg_wr | ctrl_wr | nop_cmd;
    assign wd_dis = cfg.dis;

    spi_wdog_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .cfg        (cfg)
    );

    spi_wdog_timer #(.TICKS_PER_MS(TICKS_PER_MS)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_ms),
        .kick   (kick),
        .hold   (cfg.dis),
        .code   (cfg.code),
        .expire (expire),
        .cnt    (tmr_cnt)
    );

    spi_wdog_fault u_flt (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .clr       (fault_clr),
        .alarm_off (cfg.alarm_off),
        .fault     (if_fault),
        .alarm     (alarm_force)
    );
endmodule

// File: rtl/spi_wdog_chk.sv
module spi_wdog_chk #(
    parameter int CNT_W = 13
)(
    input logic             clk,
    input logic             rst_n,
    input logic             tick_ms,
    input logic             reg_wr,
    input logic             ctrl_wr,
    input logic             nop_cmd,
    input logic             fault_clr,
    input logic             if_fault,
    input logic             alarm_force,
    input logic             wd_dis,
    input logic [CNT_W-1:0] cnt
);
    // R4 R5 R6: write and no-op strobes are mutually exclusive
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr, ctrl_wr, nop_cmd}));

    // R8
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (if_fault && !fault_clr) |=> if_fault);

    // R9
    alarm_needs_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_force |-> if_fault);

    // R7
    dis_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_dis && !if_fault) |=> !if_fault);

    // R7
    dis_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_dis |=> (cnt == '0));

    // R3
    rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(if_fault) |-> $past(tick_ms));

    // R10
    no_tick_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_ms && !reg_wr && !ctrl_wr && !nop_cmd) |=> $stable(cnt));
endmodule

bind spi_wdog spi_wdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_ms     (tick_ms),
    .reg_wr      (reg_wr),
    .ctrl_wr     (ctrl_wr),
    .nop_cmd     (nop_cmd),
    .fault_clr   (fault_clr),
    .if_fault    (if_fault),
    .alarm_force (alarm_force),
    .wd_dis      (wd_dis),
    .cnt         (tmr_cnt)
);

// File: tb/spi_wdog_test.sv
module spi_wdog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_ms = 1'b0;
    logic        reg_wr = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        nop_cmd = 1'b0;
    logic        fault_clr = 1'b0;
    logic        if_fault;
    logic        alarm_force;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    spi_wdog uut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .reg_wr(reg_wr),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .nop_cmd(nop_cmd),
        .fault_clr(fault_clr), .if_fault(if_fault), .alarm_force(alarm_force)
    );

    typedef struct packed {
        logic [2:0] code;
        int         ms;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 50},   '{3'd1, 100},  '{3'd2, 500},  '{3'd3, 1000},
        '{3'd4, 2000}, '{3'd5, 3000}, '{3'd6, 4000}, '{3'd7, 5000}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        tick_ms = 1'b1;
        repeat (n) @(negedge clk);
        tick_ms = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [15:0] w);
        ctrl_wdata = w;
        ctrl_wr = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic pulse_reg;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_nop;
        nop_cmd = 1'b1;
        @(negedge clk);
        nop_cmd = 1'b0;
    endtask

    task automatic clear(input string req);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        chk(req, if_fault, 1'b0);
        chk(req, alarm_force, 1'b0);
    endtask

    function automatic logic [15:0] word(input logic [2:0] c, input logic dis,
                                         input logic aoff);
        return {c, dis, 1'b0, aoff, 10'b0};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        chk("R1", if_fault, 1'b0);
        chk("R1", alarm_force, 1'b0);
        // R1 R3: default 1000 ms period, alarm forcing on by default
        ticks(999);
        chk("R1", if_fault, 1'b0);
        ticks(1);
        chk("R1", if_fault, 1'b1);
        chk("R9", alarm_force, 1'b1);
        // R8: fault held without clear
        idle(20);
        chk("R8", if_fault, 1'b1);
        clear("R8");

        // R2 R3 R6: every period code, exact expiry edge
        foreach (VECS[i]) begin
            wr_ctrl(word(VECS[i].code, 1'b0, 1'b0));
            ticks(VECS[i].ms - 1);
            chk("R2", if_fault, 1'b0);
            ticks(1);
            chk("R3", if_fault, 1'b1);
            clear("R8");
        end

        // R6: mid-count code change restarts with the new period
        wr_ctrl(word(3'd0, 1'b0, 1'b0));
        ticks(30);
        wr_ctrl(word(3'd1, 1'b0, 1'b0));
        ticks(99);
        chk("R6", if_fault, 1'b0);
        ticks(1);
        chk("R6", if_fault, 1'b1);
        clear("R8");

        // R4: register write restarts
        wr_ctrl(word(3'd0, 1'b0, 1'b0));
        ticks(40);
        pulse_reg();
        ticks(49);
        chk("R4", if_fault, 1'b0);
        ticks(1);
        chk("R4", if_fault, 1'b1);
        clear("R8");

        // R5: no-op restarts
        ticks(45);
        pulse_nop();
        ticks(49);
        chk("R5", if_fault, 1'b0);
        ticks(1);
        chk("R5", if_fault, 1'b1);
        clear("R8");

        // R10: cycles without tick do not count
        pulse_nop();
        ticks(30);
        idle(100);
        ticks(19);
        chk("R10", if_fault, 1'b0);
        ticks(1);
        chk("R10", if_fault, 1'b1);
        clear("R8");

        // R7: disabled holds off expiry
        wr_ctrl(word(3'd0, 1'b1, 1'b0));
        ticks(6000);
        chk("R7", if_fault, 1'b0);
        wr_ctrl(word(3'd0, 1'b0, 1'b0));
        ticks(49);
        chk("R7", if_fault, 1'b0);
        ticks(1);
        chk("R7", if_fault, 1'b1);
        // R7: disabling keeps a latched fault
        wr_ctrl(word(3'd0, 1'b1, 1'b0));
        ticks(10);
        chk("R7", if_fault, 1'b1);
        clear("R8");

        // R9: alarm forcing off, fault still raised
        wr_ctrl(word(3'd0, 1'b0, 1'b1));
        ticks(50);
        chk("R9", if_fault, 1'b1);
        chk("R9", alarm_force, 1'b0);
        wr_ctrl(word(3'd0, 1'b0, 1'b0));
        chk("R9", alarm_force, 1'b1);
        clear("R8");

        // R11: bits 11 and 9:0 ignored
        wr_ctrl(16'h0BFF);
        ticks(49);
        chk("R11", if_fault, 1'b0);
        ticks(1);
        chk("R11", if_fault, 1'b1);
        chk("R11", alarm_force, 1'b1);
        clear("R8");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule